// File: doc/BRIEF.md
# Capture Source Selector with Copy-Generation Gate

This block picks where the samples of the record path come from. One candidate is a digital audio receiver that reports a lock flag, a data-valid flag, a copy-generation code, its sample-rate code and a serial stream of 16-bit samples tagged left or right. The other candidate is the ADC path, which delivers the same kind of serial left/right stream. The receiver is used when it is locked, its data are valid, the data are marked as an original, and the host's format request can be served from it. In every other case the ADC is used.

The chosen stream is paired into stereo frames. Each frame is then reduced to the format the host asked for: full 16-bit stereo, mono (the mean of both channels), or 8-bit (the upper byte). The sample rate is not changed. The receiver can feed only one of the two reductions at a time. A request for both reductions while the receiver would otherwise be chosen raises a format error flag, and the ADC takes over. The result leaves through a one-entry valid/ready output that also tags which source produced each frame.

Top module: `rec_src_sel`

## Requirements
- R1: The receiver is the source only while `rx_lock` and `rx_data_ok` are both 1 and all the other receiver conditions hold. Otherwise the ADC is the source.
- R2: `rx_gen` code 0 marks original material, which may pass from the receiver. Any nonzero code (first generation or later) selects the ADC.
- R3: Each output frame carries `out_from_rx` = 1 when its samples came from the receiver and 0 when they came from the ADC.
- R4: The receiver can only be used when `rx_rate` is one of codes 0, 1, 2 (48, 44.1, 32 kHz) and equals `req_rate`. A locked, valid, original receiver that fails this test sets `format_error` and the ADC is used.
- R5: With `req_mono` = 1, `out_l` holds floor((L+R)/2) in two's complement and `out_r` is 0.
- R6: With `req_narrow` = 1, bits 7:0 of each output lane hold bits 15:8 of the 16-bit value (after the mono step), and bits 15:8 are 0.
- R7: If `req_mono` and `req_narrow` are both 1 while the receiver is locked, valid and original, `format_error` reads 1 from the cycle after the request and the ADC is used.
- R8: Mono 8-bit from the ADC is served normally, with `format_error` at 0, when the receiver is not usable for other reasons.
- R9: The source changes only when no left sample is waiting for its right partner. The one exception is loss of `rx_lock` while the receiver is selected: this drops the waiting left sample, and the ADC is selected at the next clock edge. A sample offered in the cycle of a switch is dropped.
- R10: A frame appears on the output in the cycle after its right sample is accepted. It stays stable while `out_valid` = 1 and `out_ready` = 0. A frame that completes while the output is full is discarded.
- R11: A right sample with no waiting left sample from the same source is ignored and produces no frame.
- R12: After reset, `out_valid` = 0, `format_error` = 0 and the ADC is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_valid | input | 1 | ADC sample present |
| adc_right | input | 1 | ADC sample is right channel (0 = left) |
| adc_data | input | 16 | ADC sample, two's complement |
| rx_valid | input | 1 | Receiver sample present |
| rx_right | input | 1 | Receiver sample is right channel |
| rx_data | input | 16 | Receiver sample, two's complement |
| rx_lock | input | 1 | Receiver locked |
| rx_data_ok | input | 1 | Receiver data flagged valid |
| rx_gen | input | 2 | Copy-generation code, 0 = original |
| rx_rate | input | 3 | Receiver rate code |
| req_rate | input | 3 | Host-requested rate code |
| req_mono | input | 1 | Host requests mono |
| req_narrow | input | 1 | Host requests 8-bit |
| out_ready | input | 1 | Consumer accepts frame |
| out_valid | output | 1 | Output frame present |
| out_l | output | 16 | Left (or mono) result |
| out_r | output | 16 | Right result, 0 in mono |
| out_from_rx | output | 1 | Frame came from the receiver |
| format_error | output | 1 | Unsupported request met a usable receiver |

## Verification
Two functions can act in the same cycle. A change of the wanted source can arrive while a left sample is waiting, in the same cycle that the right partner from the old source arrives. The bench provokes this by raising receiver lock together with the ADC's right sample. It then expects that frame to carry ADC data and the ADC tag, and the next frame to come from the receiver. The opposite case drops lock together with a receiver right sample. There the half frame must vanish and no mixed frame may appear.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic {
    SRC_ADC = 1'b0,
    SRC_RX  = 1'b1
  } src_e;

  typedef struct packed {
    logic mono;
    logic narrow;
  } fmt_t;
endpackage

// File: rtl/rss_arbiter.sv
module rss_arbiter
  import rss_pkg::*;
#(
  parameter int GEN_W    = 2,
  parameter int RATE_W   = 3,
  parameter int RX_RATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_lock,
  input  logic              rx_data_ok,
  input  logic [GEN_W-1:0]  rx_gen,
  input  logic [RATE_W-1:0] rx_rate,
  input  logic [RATE_W-1:0] req_rate,
  input  fmt_t              req_fmt,
  input  logic              frame_open,
  output src_e              sel_q,
  output logic              switch_now,
  output logic              format_error
);
  localparam logic [RATE_W-1:0] RATE_LIMIT = RATE_W'(RX_RATES);

  logic rx_usable;
  logic fmt_fits;
  logic want_rx;
  logic boundary;
  src_e sel_d;
  logic err_d;

  // decide which source is wanted this cycle
  always_comb begin
    rx_usable  = rx_lock && rx_data_ok && (rx_gen == '0);
    fmt_fits   = !(req_fmt.mono && req_fmt.narrow) &&
                 (rx_rate < RATE_LIMIT) && (rx_rate == req_rate);
    want_rx    = rx_usable && fmt_fits;
    err_d      = rx_usable && !fmt_fits;
    boundary   = !frame_open || ((sel_q == SRC_RX) && !rx_lock);
    switch_now = boundary && (want_rx != (sel_q == SRC_RX));
    sel_d      = sel_q;
    if (switch_now) sel_d = want_rx ? SRC_RX : SRC_ADC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= SRC_ADC;
      format_error <= 1'b0;
    end else begin
      sel_q        <= sel_d;
      format_error <= err_d;
    end
  end
endmodule

// File: rtl/rss_framer.sv
module rss_framer
  import rss_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  src_e                sel,
  input  logic                abort,
  input  logic                adc_valid,
  input  logic                adc_right,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                rx_valid,
  input  logic                rx_right,
  input  logic [SAMPLE_W-1:0] rx_data,
  output logic                frame_open,
  output logic                frame_done,
  output logic [SAMPLE_W-1:0] frame_l,
  output logic [SAMPLE_W-1:0] frame_r
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] s_valid;
  logic [NSRC-1:0] s_right;
  logic [SAMPLE_W-1:0] s_data [NSRC];

  assign s_valid = {rx_valid, adc_valid};
  assign s_right = {rx_right, adc_right};
  assign s_data[0] = adc_data;
  assign s_data[1] = rx_data;

  logic                v_sel;
  logic                r_sel;
  logic [SAMPLE_W-1:0] d_sel;
  logic                take;
  logic                left_en;
  logic                open_d;
  logic [SAMPLE_W-1:0] left_q;

  always_comb begin
    v_sel      = s_valid[sel];
    r_sel      = s_right[sel];
    d_sel      = s_data[sel];
    take       = v_sel && !abort;
    left_en    = take && !r_sel;
    frame_done = take && r_sel && frame_open;
    open_d     = frame_open;
    if (abort)           open_d = 1'b0;
    else if (left_en)    open_d = 1'b1;
    else if (frame_done) open_d = 1'b0;
    frame_l    = left_q;
    frame_r    = d_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_open <= 1'b0;
    else        frame_open <= open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= d_sel;
  end
endmodule

// File: rtl/rss_shaper.sv
module rss_shaper
  import rss_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_req,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  input  src_e                in_src,
  input  fmt_t                fmt,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r,
  output logic                out_from_rx
);
  localparam int PAD_W = SAMPLE_W - NARROW_W;

  logic signed [SAMPLE_W:0] sum;
  logic [SAMPLE_W-1:0] mean;
  logic [SAMPLE_W-1:0] ch   [2];
  logic [SAMPLE_W-1:0] res  [2];
  logic                load;
  logic                valid_d;

  always_comb begin
    sum   = $signed({in_l[SAMPLE_W-1], in_l}) + $signed({in_r[SAMPLE_W-1], in_r});
    mean  = SAMPLE_W'(sum >>> 1);
    ch[0] = fmt.mono ? mean : in_l;
    ch[1] = fmt.mono ? '0   : in_r;
  end

  for (genvar c = 0; c < 2; c++) begin : g_lane
    always_comb begin
      res[c] = ch[c];
      if (fmt.narrow) res[c] = {{PAD_W{1'b0}}, ch[c][SAMPLE_W-1 -: NARROW_W]};
    end
  end

  always_comb begin
    load    = load_req && (!out_valid || out_ready);
    valid_d = out_valid;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_l       <= '0;
      out_r       <= '0;
      out_from_rx <= 1'b0;
    end else if (load) begin
      out_l       <= res[0];
      out_r       <= res[1];
      out_from_rx <= (in_src == SRC_RX);
    end
  end
endmodule

// File: rtl/rec_src_sel.sv
module rec_src_sel
  import rss_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8,
  parameter int GEN_W    = 2,
  parameter int RATE_W   = 3,
  parameter int RX_RATES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adc_valid,
  input  logic                adc_right,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                rx_valid,
  input  logic                rx_right,
  input  logic [SAMPLE_W-1:0] rx_data,
  input  logic                rx_lock,
  input  logic                rx_data_ok,
  input  logic [GEN_W-1:0]    rx_gen,
  input  logic [RATE_W-1:0]   rx_rate,
  input  logic [RATE_W-1:0]   req_rate,
  input  logic                req_mono,
  input  logic                req_narrow,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r,
  output logic                out_from_rx,
  output logic                format_error
);
  fmt_t                fmt;
  src_e                sel_q;
  logic                switch_now;
  logic                frame_open;
  logic                frame_done;
  logic [SAMPLE_W-1:0] frame_l;
  logic [SAMPLE_W-1:0] frame_r;
  logic                sel_dig;

  assign fmt.mono   = req_mono;
  assign fmt.narrow = req_narrow;
  assign sel_dig    = (sel_q == SRC_RX);

  rss_arbiter #(
    .GEN_W(GEN_W), .RATE_W(RATE_W), .RX_RATES(RX_RATES)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rx_lock(rx_lock), .rx_data_ok(rx_data_ok), .rx_gen(rx_gen),
    .rx_rate(rx_rate), .req_rate(req_rate), .req_fmt(fmt),
    .frame_open(frame_open), .sel_q(sel_q), .switch_now(switch_now),
    .format_error(format_error)
  );

  rss_framer #(.SAMPLE_W(SAMPLE_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .abort(switch_now),
    .adc_valid(adc_valid), .adc_right(adc_right), .adc_data(adc_data),
    .rx_valid(rx_valid), .rx_right(rx_right), .rx_data(rx_data),
    .frame_open(frame_open), .frame_done(frame_done),
    .frame_l(frame_l), .frame_r(frame_r)
  );

  rss_shaper #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_shp (
    .clk(clk), .rst_n(rst_n), .load_req(frame_done),
    .in_l(frame_l), .in_r(frame_r), .in_src(sel_q), .fmt(fmt),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r), .out_from_rx(out_from_rx)
  );
endmodule

// File: rtl/rss_chk.sv
module rss_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_l,
  input logic [SAMPLE_W-1:0] out_r,
  input logic                out_from_rx,
  input logic                format_error,
  input logic                sel_dig,
  input logic                frame_open,
  input logic                rx_lock
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_l) && $stable(out_r) && $stable(out_from_rx)); // R10

  AST_SWITCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_dig != $past(sel_dig) |-> $past(!frame_open || !rx_lock)); // R9

  AST_LOCK_LOSS_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    sel_dig && !rx_lock |=> !sel_dig); // R9

  AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    format_error && !$past(frame_open) |-> !sel_dig); // R7
endmodule

bind rec_src_sel rss_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_l(out_l), .out_r(out_r), .out_from_rx(out_from_rx),
  .format_error(format_error), .sel_dig(sel_dig),
  .frame_open(frame_open), .rx_lock(rx_lock)
);

// File: tb/sim_rec_src_sel.sv
module sim_rec_src_sel;
  logic        clk;
  logic        rst_n;
  logic        adc_valid, adc_right;
  logic [15:0] adc_data;
  logic        rx_valid, rx_right;
  logic [15:0] rx_data;
  logic        rx_lock, rx_data_ok;
  logic [1:0]  rx_gen;
  logic [2:0]  rx_rate, req_rate;
  logic        req_mono, req_narrow, out_ready;
  logic        out_valid;
  logic [15:0] out_l, out_r;
  logic        out_from_rx, format_error;

  int total = 0;
  int failed = 0;
  bit done = 0;

  rec_src_sel u0 (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_right(adc_right),
    .adc_data(adc_data), .rx_valid(rx_valid), .rx_right(rx_right),
    .rx_data(rx_data), .rx_lock(rx_lock), .rx_data_ok(rx_data_ok),
    .rx_gen(rx_gen), .rx_rate(rx_rate), .req_rate(req_rate),
    .req_mono(req_mono), .req_narrow(req_narrow), .out_ready(out_ready),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .out_from_rx(out_from_rx), .format_error(format_error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  task automatic chk_frame(input string tag, input bit src, input logic [15:0] l, input logic [15:0] r);
    chk(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
    chk(out_from_rx == src, {tag, " src"}, int'(out_from_rx), int'(src));
    chk(out_l == l, {tag, " left"}, int'(out_l), int'(l));
    chk(out_r == r, {tag, " right"}, int'(out_r), int'(r));
  endtask

  // set receiver status and request, then let selection settle
  task automatic set_rx(input bit lk, input bit ok, input logic [1:0] g,
                        input logic [2:0] rr, input logic [2:0] qr,
                        input bit mono, input bit nar);
    @(negedge clk);
    rx_lock = lk; rx_data_ok = ok; rx_gen = g; rx_rate = rr; req_rate = qr;
    req_mono = mono; req_narrow = nar;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input bit from_rx, input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    if (from_rx) begin rx_valid = 1; rx_right = 0; rx_data = l; end
    else begin adc_valid = 1; adc_right = 0; adc_data = l; end
    @(negedge clk);
    if (from_rx) begin rx_right = 1; rx_data = r; end
    else begin adc_right = 1; adc_data = r; end
    @(negedge clk);
    rx_valid = 0; adc_valid = 0;
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R12 valid", int'(out_valid), 0);
    chk(format_error == 0, "R12 error", int'(format_error), 0);
    send(1'b1, 16'h1111, 16'h2222);  // receiver not locked: must be ignored
    chk(out_valid == 0, "R12 rx ignored", int'(out_valid), 0);
  endtask

  task automatic t_adc_default();
    send(1'b0, 16'h0123, 16'hFEDC);
    chk_frame("R1 adc when unlocked", 1'b0, 16'h0123, 16'hFEDC);
  endtask

  task automatic t_rx_pass();
    set_rx(1, 1, 2'd0, 3'd1, 3'd1, 0, 0);
    chk(format_error == 0, "R4 no error", int'(format_error), 0);
    send(1'b1, 16'h7001, 16'h8002);
    chk_frame("R3 rx original", 1'b1, 16'h7001, 16'h8002);
  endtask

  task automatic t_copy_gen();
    set_rx(1, 1, 2'd1, 3'd1, 3'd1, 0, 0);
    send(1'b0, 16'h0A0A, 16'h0B0B);
    chk_frame("R2 copy goes adc", 1'b0, 16'h0A0A, 16'h0B0B);
    set_rx(1, 0, 2'd0, 3'd1, 3'd1, 0, 0);
    send(1'b0, 16'h0C0C, 16'h0D0D);
    chk_frame("R1 data not ok", 1'b0, 16'h0C0C, 16'h0D0D);
  endtask

  task automatic t_mono();
    set_rx(1, 1, 2'd0, 3'd0, 3'd0, 1, 0);
    send(1'b1, 16'd100, 16'hFED3);    // 100 + (-301) = -201 -> -101
    chk_frame("R5 mono floor", 1'b1, 16'hFF9B, 16'h0000);
    send(1'b1, 16'd7, 16'd8);
    chk_frame("R5 mono pos", 1'b1, 16'd7, 16'h0000);
  endtask

  task automatic t_narrow();
    set_rx(1, 1, 2'd0, 3'd2, 3'd2, 0, 1);
    send(1'b1, 16'h1234, 16'hABCD);
    chk_frame("R6 narrow", 1'b1, 16'h0012, 16'h00AB);
  endtask

  task automatic t_both();
    set_rx(1, 1, 2'd0, 3'd0, 3'd0, 1, 1);
    chk(format_error == 1, "R7 error set", int'(format_error), 1);
    send(1'b0, 16'h4000, 16'h2000);
    chk_frame("R7 fallback adc", 1'b0, 16'h0030, 16'h0000);
    set_rx(0, 1, 2'd0, 3'd0, 3'd0, 1, 1);
    chk(format_error == 0, "R8 no error", int'(format_error), 0);
    send(1'b0, 16'h8000, 16'h8000);
    chk_frame("R8 adc mono narrow", 1'b0, 16'h0080, 16'h0000);
  endtask

  task automatic t_rate();
    set_rx(1, 1, 2'd0, 3'd0, 3'd1, 0, 0);
    chk(format_error == 1, "R4 mismatch error", int'(format_error), 1);
    send(1'b0, 16'h1357, 16'h2468);
    chk_frame("R4 mismatch adc", 1'b0, 16'h1357, 16'h2468);
    set_rx(1, 1, 2'd0, 3'd3, 3'd3, 0, 0);
    chk(format_error == 1, "R4 bad code error", int'(format_error), 1);
  endtask

  task automatic t_lock_loss();
    set_rx(1, 1, 2'd0, 3'd0, 3'd0, 0, 0);
    @(negedge clk);
    rx_valid = 1; rx_right = 0; rx_data = 16'h5555;
    @(negedge clk);
    rx_lock = 0; rx_right = 1; rx_data = 16'h6666;
    @(negedge clk);
    rx_valid = 0;
    chk(out_valid == 0, "R9 no mixed frame", int'(out_valid), 0);
    send(1'b0, 16'h0F0F, 16'hF0F0);
    chk_frame("R9 adc after loss", 1'b0, 16'h0F0F, 16'hF0F0);
  endtask

  task automatic t_hold_boundary();
    @(negedge clk);
    adc_valid = 1; adc_right = 0; adc_data = 16'h0101;
    @(negedge clk);
    rx_lock = 1; rx_data_ok = 1; rx_gen = 0; rx_rate = 0; req_rate = 0;
    adc_right = 1; adc_data = 16'h0202;
    @(negedge clk);
    adc_valid = 0;
    chk_frame("R9 frame stays adc", 1'b0, 16'h0101, 16'h0202);
    @(negedge clk);
    send(1'b1, 16'h0303, 16'h0404);
    chk_frame("R9 next frame rx", 1'b1, 16'h0303, 16'h0404);
  endtask

  task automatic t_backpressure();
    set_rx(0, 0, 2'd0, 3'd0, 3'd0, 0, 0);
    out_ready = 0;
    send(1'b0, 16'hAAAA, 16'hBBBB);
    chk_frame("R10 first held", 1'b0, 16'hAAAA, 16'hBBBB);
    send(1'b0, 16'hCCCC, 16'hDDDD);
    chk_frame("R10 stable", 1'b0, 16'hAAAA, 16'hBBBB);
    out_ready = 1;
    @(negedge clk);
    chk(out_valid == 0, "R10 second dropped", int'(out_valid), 0);
  endtask

  task automatic t_orphan_right();
    @(negedge clk);
    adc_valid = 1; adc_right = 1; adc_data = 16'h9999;
    @(negedge clk);
    adc_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, "R11 orphan right", int'(out_valid), 0);
    send(1'b0, 16'h1212, 16'h3434);
    chk_frame("R11 later frame", 1'b0, 16'h1212, 16'h3434);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    rst_n = 0;
    adc_valid = 0; adc_right = 0; adc_data = '0;
    rx_valid = 0; rx_right = 0; rx_data = '0;
    rx_lock = 0; rx_data_ok = 0; rx_gen = '0; rx_rate = '0; req_rate = '0;
    req_mono = 0; req_narrow = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_adc_default();
    t_rx_pass();
    t_copy_gen();
    t_mono();
    t_narrow();
    t_both();
    t_rate();
    t_lock_loss();
    t_hold_boundary();
    t_backpressure();
    t_orphan_right();
    finish_up();
  end
endmodule